// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns one frame, held as bytes in a transmit FIFO, into a bit-serial HDLC stream on a single output line. The host loads the payload into the FIFO, with its check bytes already appended, and then pulses `start`. The framer sends a programmable number of opening flags (0x7E). It then reads the FIFO one byte at a time and shifts each byte out least significant bit first. A zero bit is inserted after any run of five ones so that the payload can never imitate a flag. When the FIFO reads empty at a byte boundary, the framer sends a programmable number of closing flags. It then returns to idle, and the line stays high in idle.

The bit rate is set by `bit_en`, a one-cycle strobe in the system clock domain that marks each bit period. The line register is loaded only on edges where `bit_en` is high. This is the transmit-clock edge at which a receiver sees the data change. Any ratio of system clock to bit rate can be used, which covers rates up to 2 Mbps from an ordinary core clock.

The controller has four states:
- TX_IDLE: line held high.
- TX_OPEN: opening flags.
- TX_DATA: payload bits, plus any inserted zeros.
- TX_CLOSE: an inserted zero that is still owed, then the closing flags.

The transitions are:
- TX_IDLE→TX_OPEN on an accepted start.
- TX_OPEN→TX_DATA after the last opening flag, if the FIFO holds data.
- TX_OPEN→TX_CLOSE after the last opening flag, if the FIFO is empty (empty frame).
- TX_DATA→TX_CLOSE when the FIFO is empty at the end of a byte.
- TX_CLOSE→TX_IDLE after the last bit of the last closing flag.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, and in idle, `tx_line` is 1, `busy` is 0 and `fifo_rd` is 0. After a frame ends, the next bit period drives the line back to 1.
- R2: A `start` pulse seen in TX_IDLE is accepted, and `busy` is 1 from the following cycle. A `start` while `busy` is 1 has no effect on the bit stream or on the FIFO reads.
- R3: The frame begins with N opening flags, where N is `open_flags` sampled at start. A value of 0 is treated as 1. Each flag is 0x7E sent bit 0 first, i.e. the bit sequence 0,1,1,1,1,1,1,0.
- R4: Each payload byte is sent bit 0 first, one bit per bit period. `fifo_rd` is a single-cycle pulse per byte, and `fifo_data` is taken in that same cycle (show-ahead FIFO). The pulse comes in the bit period that sends the last bit of the preceding flag or byte.
- R5: After five consecutive payload 1 bits, a 0 bit is inserted. The run count restarts after every 0, including an inserted one. The run carries across byte boundaries, and a zero that is due after the last payload bit is sent before the closing flags.
- R6: Flag bits are never subject to zero insertion and do not count toward a payload run.
- R7: If the FIFO is empty at a byte boundary, the payload ends. M closing flags follow, where M is `close_flags` sampled at start, with 0 treated as 1. A frame with an empty FIFO at start consists of flags only.
- R8: `busy` stays 1 through the bit period whose edge drives the last bit of the last closing flag, and is 0 afterwards.
- R9: `tx_line` changes only on clock edges where `bit_en` was 1.
- R10: `fifo_rd` is never asserted while `fifo_empty` is 1. Exactly one read is made per payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| start | input | 1 | Host start command, one-cycle pulse |
| open_flags | input | FLAG_CNT_W (4) | Opening flag count (0 acts as 1) |
| close_flags | input | FLAG_CNT_W (4) | Closing flag count (0 acts as 1) |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd | output | 1 | Pop strobe; data is taken in the same cycle |
| tx_line | output | 1 | Serial output line, idles high |
| busy | output | 1 | A frame is being sent |

## Verification
The payload patterns are chosen to exercise different parts of the bit ordering and the zero insertion:
- Bytes with short runs of ones test the LSB-first order alone.
- A single 0xFF exercises insertion in the middle of a byte.
- The pair 0xF0, 0x0F builds a run across a byte boundary.
- A last byte ending in five ones forces a zero just before the closing flags.
- Payload bytes equal to 0x7E show that data is stuffed while flags are not.

Flag counts of 0, 1, several and the maximum distinguish the count-loading rule from an off-by-one. Bit periods of one, two and three clocks separate true bit-rate gating from logic that is free-running. A second start pulse in the middle of a frame checks that the command is ignored while busy.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;

    // Flag byte; sent bit 0 first it reads 0,1,1,1,1,1,1,0
    localparam logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_OPEN  = 2'd1,
        TX_DATA  = 2'd2,
        TX_CLOSE = 2'd3
    } tx_state_e;

endpackage

// File: rtl/hdlc_tx_flag_cnt.sv
module hdlc_tx_flag_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (dec && !last) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    always_comb begin
        last = (cnt_q <= ONE);
    end

    // A loaded count is never zero, so at least one flag is sent
    assert_cnt_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0))
        else $error("flag count loaded as zero");

endmodule

// File: rtl/hdlc_tx_zero_ins.sv
module hdlc_tx_zero_ins #(
    parameter int RUN    = 5,
    parameter int ONES_W = $clog2(RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic flag_mode,
    input  logic bit_val,
    output logic stuff_now
);

    localparam logic [ONES_W-1:0] RUN_LIM = ONES_W'(RUN);

    logic [ONES_W-1:0] ones_q;

    always_comb begin
        stuff_now = (ones_q == RUN_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (step) begin
            if (flag_mode || stuff_now) begin
                ones_q <= '0;
            end else if (bit_val) begin
                ones_q <= ones_q + 1'b1;
            end else begin
                ones_q <= '0;
            end
        end
    end

    // An inserted zero always ends the run
    assert_run_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && stuff_now) |=> !stuff_now)
        else $error("run not cleared after inserted zero");

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int FLAG_CNT_W = 4,
    parameter int STUFF_RUN  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  start,
    input  logic [FLAG_CNT_W-1:0] open_flags,
    input  logic [FLAG_CNT_W-1:0] close_flags,
    input  logic [BYTE_W-1:0]     fifo_data,
    input  logic                  fifo_empty,
    output logic                  fifo_rd,
    output logic                  tx_line,
    output logic                  busy
);

    localparam int                IDX_W    = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BYTE_W - 1);

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              tx_q;

    logic start_ok, emit, stuff, stuff_now, adv, last_bit, cur_bit;
    logic open_last, close_last;

    // ---------------- output / control decode ----------------
    always_comb begin
        busy     = (state_q != TX_IDLE);
        start_ok = (state_q == TX_IDLE) && start;
        emit     = bit_en && busy;
        stuff    = stuff_now && ((state_q == TX_DATA) || (state_q == TX_CLOSE));
        adv      = emit && !stuff;
        last_bit = adv && (idx_q == IDX_LAST);
        unique case (state_q)
            TX_OPEN, TX_CLOSE: cur_bit = stuff ? 1'b0 : FLAG_PATTERN[idx_q];
            TX_DATA:           cur_bit = stuff ? 1'b0 : shreg_q[idx_q];
            default:           cur_bit = 1'b1;
        endcase
        fifo_rd = last_bit && !fifo_empty &&
                  (((state_q == TX_OPEN) && open_last) || (state_q == TX_DATA));
        tx_line = tx_q;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (start) state_d = TX_OPEN;
            TX_OPEN:  if (last_bit && open_last)
                          state_d = fifo_empty ? TX_CLOSE : TX_DATA;
            TX_DATA:  if (last_bit && fifo_empty) state_d = TX_CLOSE;
            TX_CLOSE: if (last_bit && close_last) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            tx_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                idx_q <= '0;
            end else if (adv) begin
                idx_q <= idx_q + 1'b1;
            end
            if (fifo_rd) begin
                shreg_q <= fifo_data;
            end
            if (bit_en) begin
                tx_q <= busy ? cur_bit : 1'b1;
            end
        end
    end

    // ---------------- sub-blocks ----------------
    hdlc_tx_flag_cnt #(.CNT_W(FLAG_CNT_W)) u_open_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (open_flags),
        .dec      (last_bit && (state_q == TX_OPEN)),
        .last     (open_last)
    );

    hdlc_tx_flag_cnt #(.CNT_W(FLAG_CNT_W)) u_close_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (close_flags),
        .dec      (last_bit && (state_q == TX_CLOSE)),
        .last     (close_last)
    );

    hdlc_tx_zero_ins #(.RUN(STUFF_RUN)) u_zero_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (emit),
        .flag_mode (state_q != TX_DATA),
        .bit_val   (shreg_q[idx_q]),
        .stuff_now (stuff_now)
    );

    // ---------------- assertions ----------------
    assert_line_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(tx_line))
        else $error("line changed without bit strobe");

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(bit_en)) |-> tx_line)
        else $error("line low while idle");

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("start not accepted");

    assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd)
        else $error("back-to-back FIFO reads");

    assert_rd_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (busy && bit_en && !fifo_empty))
        else $error("read outside a bit strobe or from empty FIFO");

endmodule

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;

    // vector: {open[3:0], close[3:0], nbytes[3:0], b0, b1, b2, b3}
    localparam int NVEC = 7;
    localparam logic [43:0] VECS [0:NVEC-1] = '{
        {4'd1,  4'd1,  4'd2, 8'h12, 8'h34, 8'h00, 8'h00},
        {4'd3,  4'd2,  4'd1, 8'hFF, 8'h00, 8'h00, 8'h00},
        {4'd0,  4'd0,  4'd0, 8'h00, 8'h00, 8'h00, 8'h00},
        {4'd2,  4'd1,  4'd3, 8'h1F, 8'h00, 8'hF8, 8'h00},
        {4'd1,  4'd3,  4'd4, 8'h7E, 8'h7E, 8'hFF, 8'hFF},
        {4'd4,  4'd1,  4'd2, 8'hF0, 8'h0F, 8'h00, 8'h00},
        {4'd15, 4'd15, 4'd1, 8'hA5, 8'h00, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       start = 1'b0;
    logic [3:0] open_flags = '0;
    logic [3:0] close_flags = '0;
    logic [7:0] fifo_data;
    logic       fifo_empty;
    logic       fifo_rd;
    logic       tx_line;
    logic       busy;

    logic [7:0] mem [0:3];
    int         nbytes = 0;
    int         rd_ptr = 0;
    int         rd_count = 0;
    logic       ptr_clear = 1'b0;
    int         div_sel = 1;
    int         divcnt = 0;

    logic       cap [0:4095];
    int         ncap = 0;
    logic       cap_pending = 1'b0;
    logic       prev_tx = 1'b1;
    int         r9_bad = 0;

    logic       exp_bits [0:511];
    int         nexp = 0;

    int         npass = 0;
    int         ntotal = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (rd_ptr >= nbytes);
    assign fifo_data  = mem[rd_ptr[1:0]];

    hdlc_tx_framer u_hdlc_tx_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .start       (start),
        .open_flags  (open_flags),
        .close_flags (close_flags),
        .fifo_data   (fifo_data),
        .fifo_empty  (fifo_empty),
        .fifo_rd     (fifo_rd),
        .tx_line     (tx_line),
        .busy        (busy)
    );

    // bench FIFO pointer
    always @(posedge clk) begin
        if (ptr_clear) begin
            rd_ptr   <= 0;
            rd_count <= 0;
        end else if (fifo_rd) begin
            rd_ptr   <= rd_ptr + 1;
            rd_count <= rd_count + 1;
        end
    end

    // capture, line-gating monitor and bit strobe generation
    always @(negedge clk) begin
        if (cap_pending && ncap < 4096) begin
            cap[ncap] = tx_line;
            ncap = ncap + 1;
        end
        if (rst_n && (tx_line != prev_tx) && !bit_en) r9_bad = r9_bad + 1;
        prev_tx = tx_line;
        if (divcnt >= div_sel - 1) divcnt = 0;
        else divcnt = divcnt + 1;
        bit_en = (divcnt == 0);
        cap_pending = bit_en && busy;
    end

    task automatic check(input bit ok, input string msg);
        ntotal = ntotal + 1;
        if (ok) npass = npass + 1;
        else $display("FAIL %s", msg);
    endtask

    task automatic push_bit(input logic b);
        exp_bits[nexp] = b;
        nexp = nexp + 1;
    endtask

    task automatic build_exp(input logic [43:0] v);
        int nopen;
        int nclose;
        int n;
        int ones;
        logic [7:0] b;
        nopen  = (v[43:40] == 0) ? 1 : int'(v[43:40]);
        nclose = (v[39:36] == 0) ? 1 : int'(v[39:36]);
        n      = int'(v[35:32]);
        nexp   = 0;
        ones   = 0;
        for (int f = 0; f < nopen; f++)
            for (int i = 0; i < 8; i++) push_bit(8'h7E >> i);
        for (int k = 0; k < n; k++) begin
            b = v[31-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                if (ones == 5) begin
                    push_bit(1'b0);
                    ones = 0;
                end
                push_bit(b[i]);
                ones = b[i] ? ones + 1 : 0;
            end
        end
        if (ones == 5) push_bit(1'b0);
        for (int f = 0; f < nclose; f++)
            for (int i = 0; i < 8; i++) push_bit(8'h7E >> i);
    endtask

    task automatic run_frame(input int vi, input int div, input bit extra_start);
        logic [43:0] v;
        int base;
        int got;
        int diff;
        v = VECS[vi];
        build_exp(v);
        @(negedge clk);
        div_sel     = div;
        open_flags  = v[43:40];
        close_flags = v[39:36];
        nbytes      = int'(v[35:32]);
        for (int k = 0; k < 4; k++) mem[k] = v[31-8*k -: 8];
        ptr_clear   = 1'b1;
        @(negedge clk);
        ptr_clear   = 1'b0;
        base        = ncap;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        // R2: accepted start raises busy on the next cycle
        check(busy == 1'b1, $sformatf("R2 vec %0d busy after start got %0b expected 1", vi, busy));
        // change config after start: must not matter (sampled at start, R3 R7)
        open_flags  = 4'd9;
        close_flags = 4'd9;
        if (extra_start) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        got  = ncap - base;
        diff = -1;
        for (int i = 0; i < nexp; i++)
            if (diff < 0 && (i >= got || cap[base+i] != exp_bits[i])) diff = i;
        // R3 R4 R5 R6 R7 R8: full bit stream between start and end of busy
        check(got == nexp && diff < 0,
              $sformatf("R3 R4 R5 R6 R7 R8 vec %0d stream got len %0d first diff %0d expected len %0d diff -1",
                        vi, got, diff, nexp));
        // R10 R4: one read per payload byte
        check(rd_count == int'(v[35:32]),
              $sformatf("R10 R4 vec %0d reads got %0d expected %0d", vi, rd_count, v[35:32]));
        // R1 R8: back to idle with line high
        check(!busy && tx_line,
              $sformatf("R1 R8 vec %0d idle got busy=%0b line=%0b expected busy=0 line=1", vi, busy, tx_line));
    endtask

    initial begin
        #(8 * 150000);
        ntotal = ntotal + 1;
        $display("FAIL R8 watchdog expired got busy=%0b expected idle", busy);
        $display("%0d/%0d checks passed", npass, ntotal);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state, FIFO already holding data must not be read
        nbytes = 2;
        @(negedge clk);
        check(tx_line == 1'b1, $sformatf("R1 reset line got %0b expected 1", tx_line));
        check(busy == 1'b0, $sformatf("R1 reset busy got %0b expected 0", busy));
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(fifo_rd == 1'b0 && rd_count == 0 && busy == 1'b0 && tx_line == 1'b1,
              $sformatf("R1 idle after reset got rd=%0d busy=%0b line=%0b expected 0 0 1",
                        rd_count, busy, tx_line));

        // table walk with bit periods of 1, 2 and 3 clocks
        for (int vi = 0; vi < NVEC; vi++) run_frame(vi, 1 + (vi % 3), 1'b0);

        // R2: second start in mid-frame is ignored
        run_frame(3, 2, 1'b1);
        run_frame(4, 1, 1'b1);

        // R9: line only moved on strobed edges
        check(r9_bad == 0, $sformatf("R9 ungated line changes got %0d expected 0", r9_bad));

        $display("%0d/%0d checks passed", npass, ntotal);
        $finish;
    end

endmodule